// File: doc/BRIEF.md
# Single-Precision Floating-Point Sign, Compare and Classify Unit

This execution unit handles the single-precision floating-point operations that need no arithmetic datapath. These are the three sign-injection variants, the equality compare and the classify operation. Each request carries two 32-bit IEEE-754 single-precision operands. The sign is bit 31, the exponent is bits 30:23 and the fraction is bits 22:0. The request also carries the 7-bit funct7 field, the 3-bit funct3 field and the 5-bit rs2 field of the instruction. The unit decodes the operation from those three fields together.

The unit is fully pipelined. It accepts one request per cycle and returns every result a fixed number of cycles later, set by the `LAT` parameter (default 2). The latency is the same for every encoding, so the writeback port sees a uniform schedule.

Each response carries a float result, an integer result, an instruction-error flag, a NaN flag and a 5-bit exception-flag field. Arithmetic, square-root and conversion encodings are accepted as legal but produce no result. Encodings the unit does not know set the error flag instead of raising a trap.

Top module: `fp_misc_unit`

## Requirements
- R1: While `rst_n` is low, and for the first `LAT` cycles after it rises, `out_valid` stays low, even if `in_valid` was high during reset.
- R2: Each cycle with `in_valid` high produces exactly one cycle of `out_valid` exactly `LAT` clock edges later. Back-to-back requests produce back-to-back responses in order, and no response appears without a request.
- R3: With funct7 = 16, funct3 selects a sign-injection variant: 0 takes the sign of operand b, 1 takes the inverted sign of b, and 2 takes the XOR of both signs. Bits 30:0 of the float result are always bits 30:0 of operand a. The integer result and the flags are zero.
- R4: funct7 = 112 with funct3 = 1 and rs2 = 0 is classify. The integer result is a one-hot mask in bits 9:0, with the upper bits zero. Bit 0 is negative infinity, bit 1 negative normal, bit 2 negative subnormal and bit 3 negative zero. Bit 4 is positive zero, bit 5 positive subnormal, bit 6 positive normal and bit 7 positive infinity. Bit 8 is signalling NaN and bit 9 is quiet NaN. The float result is zero.
- R5: funct7 = 80 with funct3 = 2 is equality compare. The integer result is 1 when the operands are numerically equal and 0 otherwise. +0 equals -0, and any NaN operand gives 0. The float result is zero.
- R6: The flags field is {invalid, divide-by-zero, overflow, underflow, inexact}, from bit 4 down to bit 0. Only the equality compare sets the invalid flag (bit 4), and it does so exactly when an operand is a signalling NaN. A signalling NaN has exponent 255, a nonzero fraction and fraction bit 22 clear. Bits 3:0 of the flags field are always zero.
- R7: `out_nan` is high exactly when the float result has exponent 255 and a nonzero fraction.
- R8: The following encodings are recognised but produce no result: funct7 = 0, 4, 8 or 12; funct7 = 44 with rs2 = 0; and funct7 = 96 or 104 with rs2 = 0 or 1. In each case funct3 must not be 5 or 6. These give error 0, both results zero and flags zero.
- R9: Every other encoding gives error 1, both results zero, flags zero and `out_nan` low. This includes a sign-injection funct3 above 2, equality with funct3 other than 2, classify with a nonzero rs2, and funct3 = 5 or 6 on the recognised encodings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| in_a | input | 32 | First operand (rs1 value) |
| in_b | input | 32 | Second operand (rs2 value) |
| in_funct7 | input | 7 | funct7 instruction field |
| in_funct3 | input | 3 | funct3 instruction field |
| in_rs2 | input | 5 | rs2 instruction field |
| out_valid | output | 1 | Response present this cycle |
| out_fres | output | 32 | Float result |
| out_ires | output | 32 | Integer result |
| out_err | output | 1 | Unrecognised encoding |
| out_nan | output | 1 | Float result is a NaN |
| out_flags | output | 5 | Exception flags, invalid at bit 4 |

## Verification
Every response field is due exactly `LAT` clock edges after the edge that samples its request. The bench records each request together with the cycle count at which it was driven and its expected values, in a queue. On each falling edge it compares the head of the queue with the outputs only when the current cycle equals the recorded cycle plus `LAT`. A response that arrives early or late, that arrives with an empty queue, or that is missing at its due cycle is reported as a timing failure against R2. Idle gaps are mixed into the traffic so that bubbles and back-to-back streams are both covered.

// File: rtl/fp_misc_pkg.sv
package fp_misc_pkg;
  localparam int WORD_W  = 32;
  localparam int EXP_W   = 8;
  localparam int FRAC_W  = 23;
  localparam int CLASS_W = 10;
  localparam int FLAG_W  = 5;
  localparam int FLAG_INVALID = 4;

  typedef enum logic [2:0] {
    OP_PASS,   // recognised, computed elsewhere
    OP_SGN_B,
    OP_SGN_NB,
    OP_SGN_X,
    OP_EQ,
    OP_CLASS,
    OP_ILLEGAL
  } misc_op_e;

  typedef struct packed {
    logic [WORD_W-1:0] fres;
    logic [WORD_W-1:0] ires;
    logic              err;
    logic              nan;
    logic [FLAG_W-1:0] flags;
  } misc_res_t;

  function automatic logic exp_max(input logic [WORD_W-1:0] x);
    return &x[WORD_W-2 -: EXP_W];
  endfunction

  function automatic logic is_nan(input logic [WORD_W-1:0] x);
    return exp_max(x) && (|x[FRAC_W-1:0]);
  endfunction

  function automatic logic is_snan(input logic [WORD_W-1:0] x);
    return is_nan(x) && !x[FRAC_W-1];
  endfunction

  function automatic logic [CLASS_W-1:0] class_mask(input logic [WORD_W-1:0] x);
    logic sgn, ezero, fzero;
    logic [CLASS_W-1:0] m;
    sgn   = x[WORD_W-1];
    ezero = ~|x[WORD_W-2 -: EXP_W];
    fzero = ~|x[FRAC_W-1:0];
    m = '0;
    if (exp_max(x)) begin
      if (fzero)              m[sgn ? 0 : 7] = 1'b1;
      else if (x[FRAC_W-1])   m[9] = 1'b1;
      else                    m[8] = 1'b1;
    end else if (ezero) begin
      if (fzero)              m[sgn ? 3 : 4] = 1'b1;
      else                    m[sgn ? 2 : 5] = 1'b1;
    end else begin
                              m[sgn ? 1 : 6] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic fp_equal(input logic [WORD_W-1:0] a, input logic [WORD_W-1:0] b);
    if (is_nan(a) || is_nan(b)) return 1'b0;
    if ((~|a[WORD_W-2:0]) && (~|b[WORD_W-2:0])) return 1'b1;
    return a == b;
  endfunction
endpackage

// File: rtl/fp_misc_decode.sv
module fp_misc_decode
  import fp_misc_pkg::*;
(
  input  logic [6:0] funct7,
  input  logic [2:0] funct3,
  input  logic [4:0] rs2,
  output misc_op_e   op
);
  logic rm_legal;
  assign rm_legal = (funct3 != 3'd5) && (funct3 != 3'd6);

  always_comb begin
    op = OP_ILLEGAL;
    case (funct7)
      7'd0, 7'd4, 7'd8, 7'd12: if (rm_legal) op = OP_PASS;
      7'd44:  if (rm_legal && rs2 == 5'd0) op = OP_PASS;
      7'd96, 7'd104: if (rm_legal && rs2[4:1] == 4'd0) op = OP_PASS;
      7'd16: begin
        case (funct3)
          3'd0:    op = OP_SGN_B;
          3'd1:    op = OP_SGN_NB;
          3'd2:    op = OP_SGN_X;
          default: op = OP_ILLEGAL;
        endcase
      end
      7'd80:  if (funct3 == 3'd2) op = OP_EQ;
      7'd112: if (funct3 == 3'd1 && rs2 == 5'd0) op = OP_CLASS;
      default: op = OP_ILLEGAL;
    endcase
  end
endmodule

// File: rtl/fp_misc_exec.sv
module fp_misc_exec
  import fp_misc_pkg::*;
(
  input  misc_op_e          op,
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  output misc_res_t         res
);
  logic [WORD_W-2:0] body;
  assign body = a[WORD_W-2:0];

  always_comb begin
    res = '0;
    case (op)
      OP_SGN_B:   res.fres = {b[WORD_W-1], body};
      OP_SGN_NB:  res.fres = {~b[WORD_W-1], body};
      OP_SGN_X:   res.fres = {a[WORD_W-1] ^ b[WORD_W-1], body};
      OP_EQ: begin
        res.ires = {{(WORD_W-1){1'b0}}, fp_equal(a, b)};
        res.flags[FLAG_INVALID] = is_snan(a) || is_snan(b);
      end
      OP_CLASS:   res.ires = {{(WORD_W-CLASS_W){1'b0}}, class_mask(a)};
      OP_ILLEGAL: res.err = 1'b1;
      default: ;
    endcase
    res.nan = is_nan(res.fres);
  end
endmodule

// File: rtl/fp_misc_pipe.sv
module fp_misc_pipe #(
  parameter int LAT = 2,
  parameter int W   = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  output logic [W-1:0] out_data
);
  logic [LAT-1:0] vld;
  logic [W-1:0]   dat [LAT];

  for (genvar g = 0; g < LAT; g++) begin : g_stage
    logic         v_prev;
    logic [W-1:0] d_prev;
    if (g == 0) begin : g_head
      assign v_prev = in_valid;
      assign d_prev = in_data;
    end else begin : g_body
      assign v_prev = vld[g-1];
      assign d_prev = dat[g-1];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) vld[g] <= 1'b0;
      else        vld[g] <= v_prev;
    end

    always_ff @(posedge clk) begin
      if (v_prev) dat[g] <= d_prev;
    end
  end

  assign out_valid = vld[LAT-1];
  assign out_data  = dat[LAT-1];
endmodule

// File: rtl/fp_misc_unit.sv
module fp_misc_unit
  import fp_misc_pkg::*;
#(
  parameter int LAT = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] in_a,
  input  logic [31:0] in_b,
  input  logic [6:0]  in_funct7,
  input  logic [2:0]  in_funct3,
  input  logic [4:0]  in_rs2,
  output logic        out_valid,
  output logic [31:0] out_fres,
  output logic [31:0] out_ires,
  output logic        out_err,
  output logic        out_nan,
  output logic [4:0]  out_flags
);
  localparam int RES_W = $bits(misc_res_t);
  localparam int AGE_W = $clog2(LAT + 1);

  misc_op_e  dec_op;
  misc_res_t exec_res;
  misc_res_t tail_res;

  fp_misc_decode u_dec (
    .funct7 (in_funct7),
    .funct3 (in_funct3),
    .rs2    (in_rs2),
    .op     (dec_op)
  );

  fp_misc_exec u_exec (
    .op  (dec_op),
    .a   (in_a),
    .b   (in_b),
    .res (exec_res)
  );

  fp_misc_pipe #(.LAT(LAT), .W(RES_W)) u_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (exec_res),
    .out_valid (out_valid),
    .out_data  (tail_res)
  );

  assign out_fres  = tail_res.fres;
  assign out_ires  = tail_res.ires;
  assign out_err   = tail_res.err;
  assign out_nan   = tail_res.nan;
  assign out_flags = tail_res.flags;

  // cycles since reset, saturating at LAT (for the latency check)
  logic [AGE_W-1:0] age_since_rst;
  always_ff @(posedge clk) begin
    if (!rst_n) age_since_rst <= '0;
    else if (age_since_rst < AGE_W'(LAT)) age_since_rst <= age_since_rst + AGE_W'(1);
  end

  assert_no_early_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> age_since_rst >= AGE_W'(LAT));

  assert_class_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0(out_ires));

  assert_flags_low_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_flags[3:0] == 4'd0);

  assert_nan_matches_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_nan == ((out_fres[30:23] == 8'hFF) && (out_fres[22:0] != 23'd0)));

  assert_illegal_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err) |-> (out_fres == 32'd0 && out_ires == 32'd0 && out_flags == 5'd0));
endmodule

// File: tb/tb_fp_misc_unit.sv
module tb_fp_misc_unit;
  localparam int LAT = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_a = '0, in_b = '0;
  logic [6:0]  in_funct7 = '0;
  logic [2:0]  in_funct3 = '0;
  logic [4:0]  in_rs2 = '0;
  logic        out_valid, out_err, out_nan;
  logic [31:0] out_fres, out_ires;
  logic [4:0]  out_flags;

  fp_misc_unit #(.LAT(LAT)) dut (.*);

  always #10 clk = ~clk;  // 50 MHz

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int          due;
    logic [31:0] fr, ir;
    logic        er, nn;
    logic [4:0]  fl;
    string       req;
  } exp_t;
  exp_t pend[$];

  function automatic int class_index(input logic [31:0] x);
    int e = int'(x[30:23]);
    bit neg = x[31];
    bit zf = (x[22:0] == 0);
    if (e == 255) return zf ? (neg ? 0 : 7) : (x[22] ? 9 : 8);
    if (e == 0)   return zf ? (neg ? 3 : 4) : (neg ? 2 : 5);
    return neg ? 1 : 6;
  endfunction

  function automatic bit tb_nan(input logic [31:0] x);
    return (x[30:23] == 8'd255) && (x[22:0] != 0);
  endfunction

  function automatic void model(input logic [6:0] f7, input logic [2:0] f3, input logic [4:0] r2,
                                input logic [31:0] a, input logic [31:0] b,
                                output logic [31:0] fr, output logic [31:0] ir,
                                output logic er, output logic [4:0] fl, output string req);
    bit rm_ok = (f3 != 5) && (f3 != 6);
    fr = 0; ir = 0; er = 0; fl = 0; req = "R9";
    if (f7 == 0 || f7 == 4 || f7 == 8 || f7 == 12) begin er = !rm_ok; req = rm_ok ? "R8" : "R9"; end
    else if (f7 == 44) begin er = !(rm_ok && r2 == 0); req = er ? "R9" : "R8"; end
    else if (f7 == 96 || f7 == 104) begin er = !(rm_ok && r2 < 2); req = er ? "R9" : "R8"; end
    else if (f7 == 16 && f3 <= 2) begin
      req = "R3";
      case (f3)
        3'd0: fr = {b[31], a[30:0]};
        3'd1: fr = {!b[31], a[30:0]};
        default: fr = {a[31] != b[31], a[30:0]};
      endcase
    end
    else if (f7 == 80 && f3 == 2) begin
      bit na = tb_nan(a), nb = tb_nan(b);
      req = "R5";
      if (!na && !nb && (a == b || (a[30:0] == 0 && b[30:0] == 0))) ir = 1;
      if ((na && !a[22]) || (nb && !b[22])) begin fl = 5'b10000; req = "R6"; end
    end
    else if (f7 == 112 && f3 == 1 && r2 == 0) begin
      req = "R4";
      ir = 32'd1 << class_index(a);
    end
    else er = 1;
  endfunction

  task automatic check_out();
    if (pend.size() > 0 && pend[0].due == cyc) begin
      exp_t e = pend.pop_front();
      checks++;
      if (!out_valid) begin
        errors++;
        $display("FAIL R2 missing response at cycle %0d: out_valid=0 expected 1", cyc);
      end else if (out_fres !== e.fr || out_ires !== e.ir || out_err !== e.er ||
                   out_nan !== e.nn || out_flags !== e.fl) begin
        errors++;
        $display("FAIL %s cycle %0d: fres=%h ires=%h err=%b nan=%b flags=%b expected fres=%h ires=%h err=%b nan=%b flags=%b",
                 e.req, cyc, out_fres, out_ires, out_err, out_nan, out_flags,
                 e.fr, e.ir, e.er, e.nn, e.fl);
      end
      if (e.nn) begin
        checks++;  // R7 NaN flag on a NaN float result
        if (out_nan !== 1'b1) begin
          errors++;
          $display("FAIL R7 out_nan=%b expected 1", out_nan);
        end
      end
    end else if (out_valid) begin
      checks++;
      errors++;
      $display("FAIL R2 unexpected response at cycle %0d: out_valid=1 expected 0", cyc);
    end
  endtask

  task automatic issue(input logic [6:0] f7, input logic [2:0] f3, input logic [4:0] r2,
                       input logic [31:0] a, input logic [31:0] b);
    exp_t e;
    @(negedge clk);
    check_out();
    in_valid = 1'b1; in_funct7 = f7; in_funct3 = f3; in_rs2 = r2; in_a = a; in_b = b;
    model(f7, f3, r2, a, b, e.fr, e.ir, e.er, e.fl, e.req);
    e.nn = tb_nan(e.fr);
    e.due = cyc + LAT;
    pend.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    check_out();
    in_valid = 1'b0;
    in_a = $urandom; in_b = $urandom;
  endtask

  function automatic logic [31:0] pick_operand();
    logic [31:0] v;
    logic s = 1'($urandom);
    case ($urandom_range(0, 8))
      0: v = 32'h0000_0000;
      1: v = 32'h7F80_0000;
      2: v = 32'h7FC0_0000 | ($urandom & 32'h003F_FFFF);
      3: v = 32'h7F80_0001 | ($urandom & 32'h001F_FFFF);
      4: v = $urandom & 32'h007F_FFFF;
      5: v = 32'h7F7F_FFFF;
      6: v = 32'h3F80_0000;
      default: v = $urandom;
    endcase
    v[31] = s;
    return v;
  endfunction

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired: done=0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h5EED_1234);

    // R1: request held during reset must not emerge
    in_valid = 1'b1; in_funct7 = 7'd16;
    repeat (3) begin
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b0) begin errors++; $display("FAIL R1 out_valid=%b expected 0 in reset", out_valid); end
    end
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (LAT + 2) begin
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b0) begin errors++; $display("FAIL R1 out_valid=%b expected 0 after reset", out_valid); end
    end

    // R3 sign injection corners, incl. NaN body for R7
    issue(7'd16, 3'd0, 5'd2, 32'h3F80_0000, 32'h8000_0000);
    issue(7'd16, 3'd1, 5'd2, 32'hBF80_0000, 32'h8000_0000);
    issue(7'd16, 3'd2, 5'd2, 32'hFFC0_0001, 32'h8000_0000);
    issue(7'd16, 3'd0, 5'd2, 32'h7F80_0001, 32'h0000_0000);
    // R5 zeros and NaNs, R6 invalid only on signalling NaN
    issue(7'd80, 3'd2, 5'd0, 32'h0000_0000, 32'h8000_0000);
    issue(7'd80, 3'd2, 5'd0, 32'h7FC0_0000, 32'h7FC0_0000);
    issue(7'd80, 3'd2, 5'd0, 32'h7F80_0001, 32'h3F80_0000);
    issue(7'd80, 3'd2, 5'd0, 32'h4049_0FDB, 32'h4049_0FDB);
    idle();
    // R4 each class bit
    issue(7'd112, 3'd1, 5'd0, 32'hFF80_0000, 0);
    issue(7'd112, 3'd1, 5'd0, 32'hBF80_0000, 0);
    issue(7'd112, 3'd1, 5'd0, 32'h8000_0001, 0);
    issue(7'd112, 3'd1, 5'd0, 32'h8000_0000, 0);
    issue(7'd112, 3'd1, 5'd0, 32'h0000_0000, 0);
    issue(7'd112, 3'd1, 5'd0, 32'h0040_0000, 0);
    issue(7'd112, 3'd1, 5'd0, 32'h3F80_0000, 0);
    issue(7'd112, 3'd1, 5'd0, 32'h7F80_0000, 0);
    issue(7'd112, 3'd1, 5'd0, 32'h7FA0_0000, 0);
    issue(7'd112, 3'd1, 5'd0, 32'h7FC0_0000, 0);
    // R8 recognised pass-through, R9 illegal variants
    issue(7'd0,   3'd7, 5'd3, 32'h3F80_0000, 32'h3F80_0000);
    issue(7'd44,  3'd0, 5'd0, 32'h7FC0_0000, 0);
    issue(7'd104, 3'd1, 5'd1, 32'h7FC0_0000, 0);
    issue(7'd44,  3'd0, 5'd1, 32'h3F80_0000, 0);
    issue(7'd8,   3'd5, 5'd0, 32'h3F80_0000, 0);
    issue(7'd112, 3'd1, 5'd1, 32'h3F80_0000, 0);
    issue(7'd16,  3'd3, 5'd0, 32'h7FC0_0000, 0);
    issue(7'd80,  3'd1, 5'd0, 32'h3F80_0000, 32'h3F80_0000);
    idle(); idle();

    // constrained random traffic with bubbles (R2 ordering and spacing)
    for (int i = 0; i < 3000; i++) begin
      logic [6:0] f7; logic [2:0] f3; logic [4:0] r2;
      logic [31:0] a, b;
      f3 = 3'($urandom); r2 = 5'($urandom);
      case ($urandom_range(0, 7))
        0, 1: begin f7 = 7'd16; f3 = 3'($urandom_range(0, 3)); end
        2, 3: begin f7 = 7'd80; f3 = ($urandom_range(0, 4) == 0) ? 3'($urandom) : 3'd2; end
        4:    begin f7 = 7'd112; f3 = 3'd1; r2 = ($urandom_range(0, 4) == 0) ? 5'($urandom) : 5'd0; end
        5:    begin
                case ($urandom_range(0, 5))
                  0: f7 = 7'd0; 1: f7 = 7'd4; 2: f7 = 7'd8; 3: f7 = 7'd12;
                  4: f7 = 7'd44; default: f7 = 7'd96;
                endcase
                r2 = 5'($urandom_range(0, 2));
              end
        default: f7 = 7'($urandom);
      endcase
      a = pick_operand();
      b = ($urandom_range(0, 3) == 0) ? a : pick_operand();
      if ($urandom_range(0, 4) == 0) idle();
      issue(f7, f3, r2, a, b);
    end
    repeat (LAT + 3) idle();
    if (pend.size() != 0) begin
      checks++; errors++;
      $display("FAIL R2 %0d responses outstanding, expected 0", pend.size());
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule